// File: doc/BRIEF.md
# Search Step Triplet Unit

This block carries out one branch step of a single-wire bus address search. A start strobe makes it run three bit slots back to back on the open-drain line. The first read slot returns the address bit that the attached devices hold. The second read slot returns the complement of that bit. From these two reads and a preferred-direction input, the unit picks a branch direction. It then sends that direction in a write slot, so that devices whose bit differs drop out of the search.

When the step ends, a one-cycle done pulse appears together with a 3-bit status. The status reports the two read values and the direction taken. If both reads return 1, no device answered. The unit then reports an error status and leaves out the write slot. The surrounding search loop, with its bit counter, discrepancy tracking, bus reset and search command, belongs to the caller.

Slot timing is counted in clock cycles and set by parameters. These cover the short low time used by read and write-1 slots, the long low time of a write-0 slot, the sample point and the slot length.

Top module: `ow_triplet_unit`

## Requirements
- R1: An accepted start runs a read slot for the ID bit and then a read slot for the complement bit. Each read slot pulls the line low for `T_LOW1` cycles and samples it at cycle `T_SAMPLE`. A device holding the line low during a read slot reads as 0.
- R2: The status bits are laid out as follows: bit 0 holds the ID read, bit 1 holds the complement read, and bit 2 holds the direction taken.
- R3: When both reads return 1, status is 3 (3'b011) and no third slot is issued.
- R4: When both reads return 0, the direction written is the preferred direction captured at the accepted start. Status is 4 when that direction is 1 and 0 when it is 0.
- R5: When exactly one read returns 1, the direction equals the ID read. Status is 5 when the ID read is 1 and 2 when it is 0.
- R6: Except in the error case of R3, the direction is sent as a third slot right after the two reads. A 1 is sent as a low time of `T_LOW1` cycles and a 0 as a low time of `T_LOW0` cycles.
- R7: `busy` is high from the cycle after an accepted start until the done pulse. `done` is high for exactly one cycle per operation.
- R8: `status` changes only in the cycle in which `done` is high. It is held from then on, through any later start, until the next done.
- R9: A start strobe, or a change of `pref_dir`, while `busy` is high has no effect. The operation in progress keeps its slots, its direction and its status.
- R10: After reset, `busy`, `done` and `bus_pull_low` are 0 and `status` is 0. The line is never pulled low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe for one triplet step |
| pref_dir | input | 1 | Preferred branch direction, used when both reads are 0 |
| bus_in | input | 1 | Sensed line level (asynchronous, synchronised inside) |
| bus_pull_low | output | 1 | 1 pulls the open-drain line low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| status | output | 3 | {direction, complement read, ID read} |

## Verification
The hardest case to reach from the ports is a start request that lands in the middle of a running step, combined with a change of preferred direction. Reaching it needs the device response and the strobe to be placed at a precise point within the slots. The bench models the devices as a line driver that pulls low in the first or second read slot, depending on the bit pattern chosen for the step. It counts the master's falling edges and measures each low time. It then fires a stray start with the opposite preference during the complement read. The scoreboard expects the step to end with the original direction and exactly three slots.

// File: rtl/ow_triplet_pkg.sv
// Package: shared types for the search triplet unit.
// Assumes: nothing beyond standard SystemVerilog.
package ow_triplet_pkg;

    localparam int STATUS_W = 3;

    // Sequencer phases of one triplet step.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD_ID = 2'd1,
        PH_RD_CMP = 2'd2,
        PH_WR_DIR = 2'd3
    } phase_t;

    // Error code returned when no device answered.
    localparam logic [STATUS_W-1:0] STATUS_NODEV = 3'b011;

endpackage

// File: rtl/ow_slot_engine.sv
// Module: ow_slot_engine
// Runs one time slot on an open-drain line. It pulls low for a short time
// (read or write-1) or a long time (write-0), samples the synchronised line
// at a fixed cycle and pulses slot_done in the last cycle of the slot.
// Assumes: go is issued only while idle or in the slot_done cycle;
// T_LOW1 < T_SAMPLE < T_LOW0 < T_SLOT.
module ow_slot_engine #(
    parameter int T_LOW1   = 6,
    parameter int T_LOW0   = 60,
    parameter int T_SAMPLE = 15,
    parameter int T_SLOT   = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic wbit,
    input  logic bus_in,
    output logic pull_low,
    output logic slot_done,
    output logic rbit
);
    localparam int CW = $clog2(T_SLOT + 1);
    localparam logic [CW-1:0] LAST    = CW'(T_SLOT - 1);
    localparam logic [CW-1:0] SMP_AT  = CW'(T_SAMPLE - 1);
    localparam logic [CW-1:0] LOW1_C  = CW'(T_LOW1);
    localparam logic [CW-1:0] LOW0_C  = CW'(T_LOW0);

    logic          active;
    logic          wb_q;
    logic [CW-1:0] cnt;
    logic [1:0]    sync_q;

    // Two-flop synchroniser for the sensed line level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], bus_in};
    end

    // Slot counter: restart on go, stop after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            wb_q   <= 1'b1;
        end else if (go) begin
            active <= 1'b1;
            cnt    <= '0;
            wb_q   <= wbit;
        end else if (active) begin
            if (cnt == LAST) active <= 1'b0;
            else             cnt    <= cnt + 1'b1;
        end
    end

    // Read sample taken at the fixed sample point.
    always_ff @(posedge clk) begin
        if (!rst_n)                         rbit <= 1'b1;
        else if (active && cnt == SMP_AT)   rbit <= sync_q[1];
    end

    // Line drive and end-of-slot strobe.
    always_comb begin
        pull_low  = active && (cnt < (wb_q ? LOW1_C : LOW0_C));
        slot_done = active && (cnt == LAST);
    end
endmodule

// File: rtl/ow_triplet_ctrl.sv
// Module: ow_triplet_ctrl
// Sequences the two read slots and the optional direction write. It picks
// the direction and registers the status with a one-cycle done pulse.
// Assumes: slot_done and rbit come from ow_slot_engine; rbit is valid in
// the slot_done cycle.
module ow_triplet_ctrl
    import ow_triplet_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                pref_dir,
    input  logic                slot_done,
    input  logic                rbit,
    output logic                slot_go,
    output logic                slot_wbit,
    output logic                busy,
    output logic                done,
    output logic [STATUS_W-1:0] status
);
    phase_t ph;
    logic   pref_q;
    logic   id_q;
    logic   cmp_q;
    logic   dir_q;
    logic   dir_next;
    logic   no_dev;

    // Direction choice from the ID read and the complement read in flight.
    always_comb begin
        no_dev   = id_q & rbit;
        dir_next = (id_q ^ rbit) ? id_q : pref_q;
    end

    // Slot launch: a read slot on start and after the ID read, a write after the complement read.
    always_comb begin
        slot_go   = 1'b0;
        slot_wbit = 1'b1;
        case (ph)
            PH_IDLE:   slot_go = start;
            PH_RD_ID:  slot_go = slot_done;
            PH_RD_CMP: begin
                slot_go   = slot_done && !no_dev;
                slot_wbit = dir_next;
            end
            default:   slot_go = 1'b0;
        endcase
    end

    // Phase register, captured reads and registered status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_IDLE;
            done   <= 1'b0;
            status <= '0;
            pref_q <= 1'b0;
            id_q   <= 1'b0;
            cmp_q  <= 1'b0;
            dir_q  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_IDLE: if (start) begin
                    pref_q <= pref_dir;
                    ph     <= PH_RD_ID;
                end
                PH_RD_ID: if (slot_done) begin
                    id_q <= rbit;
                    ph   <= PH_RD_CMP;
                end
                PH_RD_CMP: if (slot_done) begin
                    cmp_q <= rbit;
                    if (no_dev) begin
                        status <= STATUS_NODEV;
                        done   <= 1'b1;
                        ph     <= PH_IDLE;
                    end else begin
                        dir_q <= dir_next;
                        ph    <= PH_WR_DIR;
                    end
                end
                PH_WR_DIR: if (slot_done) begin
                    status <= {dir_q, cmp_q, id_q};
                    done   <= 1'b1;
                    ph     <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Busy while any phase other than idle is active.
    always_comb busy = (ph != PH_IDLE);
endmodule

// File: rtl/ow_triplet_unit.sv
// Module: ow_triplet_unit (top)
// One search-step triplet on an open-drain line: read the ID bit, read the
// complement, write the chosen direction, report a 3-bit status.
// Assumes: external open-drain pad; bus_in is the sensed line level.
module ow_triplet_unit #(
    parameter int T_LOW1   = 6,
    parameter int T_LOW0   = 60,
    parameter int T_SAMPLE = 15,
    parameter int T_SLOT   = 70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       pref_dir,
    input  logic       bus_in,
    output logic       bus_pull_low,
    output logic       busy,
    output logic       done,
    output logic [2:0] status
);
    logic slot_go;
    logic slot_wbit;
    logic slot_done;
    logic rbit;

    ow_slot_engine #(
        .T_LOW1  (T_LOW1),
        .T_LOW0  (T_LOW0),
        .T_SAMPLE(T_SAMPLE),
        .T_SLOT  (T_SLOT)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (slot_go),
        .wbit     (slot_wbit),
        .bus_in   (bus_in),
        .pull_low (bus_pull_low),
        .slot_done(slot_done),
        .rbit     (rbit)
    );

    ow_triplet_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .pref_dir (pref_dir),
        .slot_done(slot_done),
        .rbit     (rbit),
        .slot_go  (slot_go),
        .slot_wbit(slot_wbit),
        .busy     (busy),
        .done     (done),
        .status   (status)
    );
endmodule

// File: rtl/ow_triplet_chk.sv
// Module: ow_triplet_chk
// Property checker bound to ow_triplet_unit; observes its ports only.
module ow_triplet_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [2:0] status,
    input logic       bus_pull_low
);
    // R8: status moves only together with done.
    assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(status));

    // R7: done is a single-cycle pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done ends an operation, so busy must have been high just before.
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R3: both reads 1 never reports a direction of 1.
    assert_nodev_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status[1:0] == 2'b11) |-> !status[2]);

    // R5: a single 1 read forces the direction to the ID read.
    assert_single_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (status[0] ^ status[1])) |-> (status[2] == status[0]));

    // R10: the line is never pulled while idle.
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_pull_low);

    // R9: a start while busy does not abort the operation.
    assert_busy_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start && $past(busy)) |=> (busy || done));
endmodule

bind ow_triplet_unit ow_triplet_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .status      (status),
    .bus_pull_low(bus_pull_low)
);

// File: tb/sim_ow_triplet_unit.sv
module sim_ow_triplet_unit;
    localparam int T_LOW1 = 6;
    localparam int T_LOW0 = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic pref_dir = 1'b0;
    logic bus_in;
    logic bus_pull_low, busy, done;
    logic [2:0] status;

    int n_checks = 0;
    int n_fail = 0;

    // Device model: bits driven in read slot 1 (ID) and 2 (complement).
    logic dev_id = 1'b1, dev_cmp = 1'b1;
    logic dev_low = 1'b0;
    int   slot_cnt = 0;
    int   phase = 0;
    int   low_len [0:3];
    logic prev_pull = 1'b0;

    typedef struct { logic [2:0] st; int nslots; } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    assign bus_in = ~bus_pull_low & ~dev_low;

    ow_triplet_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir),
        .bus_in(bus_in), .bus_pull_low(bus_pull_low), .busy(busy),
        .done(done), .status(status)
    );

    task automatic check(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Bus observer: counts master slots, measures low times, drives device.
    always @(negedge clk) begin
        if (bus_pull_low && !prev_pull) begin
            if (slot_cnt < 4) low_len[slot_cnt] = 1;
            slot_cnt = slot_cnt + 1;
            phase = 0;
        end else begin
            if (bus_pull_low && slot_cnt >= 1 && slot_cnt <= 4)
                low_len[slot_cnt-1] = low_len[slot_cnt-1] + 1;
            phase = phase + 1;
        end
        prev_pull = bus_pull_low;
        dev_low = (phase < 30) &&
                  ((slot_cnt == 1 && !dev_id) || (slot_cnt == 2 && !dev_cmp));
    end

    // Monitor: pops the expectation on each done pulse and compares.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R2 status", int'(status), int'(e.st));
                check("R3 R6 slot count", slot_cnt, e.nslots);
                check("R1 id read low time", low_len[0], T_LOW1);
                check("R1 cmp read low time", low_len[1], T_LOW1);
                if (e.nslots == 3)
                    check("R6 write low time", low_len[2],
                          e.st[2] ? T_LOW1 : T_LOW0);
            end
        end
    end

    // Driver: one triplet step; optional stray start with flipped pref mid-run.
    task automatic run_op(input logic id, input logic cmp, input logic pref,
                          input logic stray);
        exp_t e;
        logic d;
        dev_id = id; dev_cmp = cmp;
        if (id && cmp) begin
            e.st = 3'b011; e.nslots = 2;
        end else begin
            d = (id ^ cmp) ? id : pref;
            e.st = {d, cmp, id}; e.nslots = 3;
        end
        exp_q.push_back(e);
        @(negedge clk);
        slot_cnt = 0;
        pref_dir = pref;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 busy after start", int'(busy), 1);
        if (stray) begin
            repeat (100) @(negedge clk);
            pref_dir = ~pref;
            start = 1'b1;   // R9: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        check("R7 done one cycle", int'(done), 0);
        check("R7 idle after done", int'(busy), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [2:0] held;
        repeat (4) @(negedge clk);
        // R10 reset state
        check("R10 busy", int'(busy), 0);
        check("R10 done", int'(done), 0);
        check("R10 pull", int'(bus_pull_low), 0);
        check("R10 status", int'(status), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 pull idle", int'(bus_pull_low), 0);

        run_op(1'b1, 1'b1, 1'b0, 1'b0);  // R3 no device
        run_op(1'b1, 1'b1, 1'b1, 1'b0);  // R3
        run_op(1'b0, 1'b0, 1'b1, 1'b0);  // R4 -> 4
        run_op(1'b0, 1'b0, 1'b0, 1'b0);  // R4 -> 0
        run_op(1'b1, 1'b0, 1'b0, 1'b0);  // R5 -> 5
        run_op(1'b0, 1'b1, 1'b1, 1'b0);  // R5 -> 2
        run_op(1'b1, 1'b0, 1'b1, 1'b0);  // R5 -> 5
        run_op(1'b0, 1'b1, 1'b0, 1'b0);  // R5 -> 2

        // R8 hold after done and through the next start
        held = status;
        repeat (20) @(negedge clk);
        check("R8 status held idle", int'(status), int'(held));
        dev_id = 1'b0; dev_cmp = 1'b0;
        exp_q.push_back('{st: 3'b100, nslots: 3});
        slot_cnt = 0;
        pref_dir = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        check("R8 status held in run", int'(status), int'(held));
        while (!done) @(negedge clk);
        @(negedge clk);

        // R9 stray start with flipped preference while busy
        run_op(1'b0, 1'b0, 1'b1, 1'b1);
        run_op(1'b0, 1'b0, 1'b0, 1'b1);
        repeat (100) @(negedge clk);
        check("R9 no extra slots", slot_cnt, 3);
        check("R9 queue drained", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule